// File: doc/BRIEF.md
# SPI FIFO Status and Error Flags

This block holds the status and interrupt-flag logic for an SPI controller whose transmit and receive FIFOs each hold 32 entries of 32 bits. It does not store data. It counts how many entries each FIFO holds, based on four event strobes:

- a software write into the transmit FIFO;
- the shift engine taking a word from the transmit FIFO;
- a received word arriving from the shift engine;
- a software read from the receive FIFO.

From these counts it derives the live full and empty flags.

Illegal events are blocked, and each one sets its own sticky error flag. A push into a full FIFO is dropped. A pop from an empty FIFO leaves the count unchanged. A completion strobe sets a sticky ready flag. Software clears the ready flag and the error flags by writing ones to their bit positions. A second status word reports the number of free transmit slots and the number of filled receive entries. One interrupt line combines the ready flag, when it is enabled, with the error summary.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset, status2_o reads 32 in bits 5:0 and 0 in bits 21:16. status_o has tx empty (bit 1) and rx empty (bit 3) set and every other flag clear, and irq_o is low.
- R2: An accepted transmit write lowers the free-slot count in status2_o[5:0] by one, and an accepted transmit pop raises it by one. Bit 0 (tx full) is set exactly when the count is 0, and bit 1 (tx empty) exactly when it is 32.
- R3: A transmit write while the TX FIFO is full leaves the count unchanged and sets the sticky tx overflow flag, bit 8.
- R4: A transmit pop while the TX FIFO is empty leaves the count unchanged and sets the sticky tx underflow flag, bit 9.
- R5: An accepted received word raises the filled count in status2_o[21:16] by one, and an accepted software read lowers it by one. Bit 2 (rx full) is set exactly at 32 and bit 3 (rx empty) exactly at 0.
- R6: A received word that arrives while the RX FIFO is full is dropped and sets the sticky rx overflow flag, bit 10.
- R7: A software read while the RX FIFO is empty leaves the count at 0 and sets the sticky rx underflow flag, bit 11.
- R8: The sticky flags (bits 8 to 11 and 13) keep their value until a status write has a 1 in their position. A 0 in the written word leaves the flag unchanged.
- R9: When an error event and a clear of the same flag fall in one cycle, the flag ends up set.
- R10: Bit 12 (error summary) is set exactly when at least one of bits 8 to 11 is set.
- R11: A pulse on done_i sets the sticky ready flag, bit 13.
- R12: irq_o equals (ready AND rdy_ie_i) OR error summary.
- R13: Bit 4 of status_o follows busy_i in the same cycle.
- R14: A push and a pop that are both accepted in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_wr_i | input | 1 | Software write into the TX FIFO |
| tx_pop_i | input | 1 | Shift engine takes a TX word |
| rx_push_i | input | 1 | Shift engine delivers an RX word |
| rx_rd_i | input | 1 | Software read from the RX FIFO |
| busy_i | input | 1 | Shift engine busy (live) |
| done_i | input | 1 | Transfer completion strobe |
| rdy_ie_i | input | 1 | Ready interrupt enable |
| sts_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata_i | input | 32 | Status write data |
| status_o | output | 32 | Live flags, sticky flags and error summary |
| status2_o | output | 32 | TX free count [5:0], RX filled count [21:16] |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-line assertions check on every cycle the behaviours that hold in any state:
- the counters stay within 0 to 32;
- an accepted push or pop moves a count by exactly one, and a blocked push leaves it unchanged;
- each sticky flag rises after its set event and is held or dropped as the clear and set inputs require;
- the interrupt is asserted whenever the error summary is.

Only the directed scenarios can show the rest: the exact bit positions software sees, the reset values, that writing zeros leaves flags alone, the outcome when a set and a clear collide, and the counts at the 0 and 32 boundaries reached through long sequences.

// File: rtl/spi_fifo_status_pkg.sv
package spi_fifo_status_pkg;
  localparam int FIFO_DEPTH = 32;

  // status_o bit positions
  localparam int B_TX_FULL  = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_RX_EMPTY = 3;
  localparam int B_BUSY     = 4;
  localparam int B_TX_OVF   = 8;
  localparam int B_TX_UNF   = 9;
  localparam int B_RX_OVF   = 10;
  localparam int B_RX_UNF   = 11;
  localparam int B_ERR      = 12;
  localparam int B_READY    = 13;

  // status2_o field offsets
  localparam int S2_TX_LSB = 0;
  localparam int S2_RX_LSB = 16;

  // sticky flag bank index
  localparam int F_TX_OVF = 0;
  localparam int F_TX_UNF = 1;
  localparam int F_RX_OVF = 2;
  localparam int F_RX_UNF = 3;
  localparam int F_READY  = 4;
  localparam int N_FLAGS  = 5;
  localparam int N_ERR    = 4;
endpackage

// File: rtl/spi_fifo_occ.sv
module spi_fifo_occ #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_drop_o,
  output logic          pop_miss_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic push_ok, pop_ok;

  assign full_o      = (count_o == DEPTH_C);
  assign empty_o     = (count_o == '0);
  assign push_ok     = push_i && !full_o;
  assign pop_ok      = pop_i && !empty_o;
  assign push_drop_o = push_i && full_o;
  assign pop_miss_o  = pop_i && empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else         count_o <= count_o + CW'(push_ok) - CW'(pop_ok);
  end

  p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= DEPTH_C);
  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> count_o == $past(count_o) + 1'b1);
  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> count_o == $past(count_o) - 1'b1);
  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> $stable(count_o));
  p_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> $stable(count_o));
  p_both_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o) |=> $stable(count_o));
endmodule

// File: rtl/spi_sticky_bank.sv
module spi_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    // set has priority over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end

    p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
    p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
    p_nospur_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_status_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_wr_i,
  input  logic        tx_pop_i,
  input  logic        rx_push_i,
  input  logic        rx_rd_i,
  input  logic        busy_i,
  input  logic        done_i,
  input  logic        rdy_ie_i,
  input  logic        sts_wr_i,
  input  logic [31:0] sts_wdata_i,
  output logic [31:0] status_o,
  output logic [31:0] status2_o,
  output logic        irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_ovf_ev, tx_unf_ev, rx_ovf_ev, rx_unf_ev;
  logic [N_FLAGS-1:0] set_v, clr_v, flags;
  logic err_any;
  logic unused_wdata;

  spi_fifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk_i, .rst_ni,
    .push_i(tx_wr_i), .pop_i(tx_pop_i),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty),
    .push_drop_o(tx_ovf_ev), .pop_miss_o(tx_unf_ev)
  );

  spi_fifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk_i, .rst_ni,
    .push_i(rx_push_i), .pop_i(rx_rd_i),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty),
    .push_drop_o(rx_ovf_ev), .pop_miss_o(rx_unf_ev)
  );

  always_comb begin
    set_v           = '0;
    set_v[F_TX_OVF] = tx_ovf_ev;
    set_v[F_TX_UNF] = tx_unf_ev;
    set_v[F_RX_OVF] = rx_ovf_ev;
    set_v[F_RX_UNF] = rx_unf_ev;
    set_v[F_READY]  = done_i;
    clr_v           = '0;
    if (sts_wr_i) begin
      clr_v[F_TX_OVF] = sts_wdata_i[B_TX_OVF];
      clr_v[F_TX_UNF] = sts_wdata_i[B_TX_UNF];
      clr_v[F_RX_OVF] = sts_wdata_i[B_RX_OVF];
      clr_v[F_RX_UNF] = sts_wdata_i[B_RX_UNF];
      clr_v[F_READY]  = sts_wdata_i[B_READY];
    end
  end

  assign unused_wdata = ^sts_wdata_i;

  spi_sticky_bank #(.N(N_FLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .flag_o(flags)
  );

  assign err_any = |flags[N_ERR-1:0];
  assign tx_free = CW'(DEPTH) - tx_cnt;

  always_comb begin
    status_o             = '0;
    status_o[B_TX_FULL]  = tx_full;
    status_o[B_TX_EMPTY] = tx_empty;
    status_o[B_RX_FULL]  = rx_full;
    status_o[B_RX_EMPTY] = rx_empty;
    status_o[B_BUSY]     = busy_i;
    status_o[B_TX_OVF]   = flags[F_TX_OVF];
    status_o[B_TX_UNF]   = flags[F_TX_UNF];
    status_o[B_RX_OVF]   = flags[F_RX_OVF];
    status_o[B_RX_UNF]   = flags[F_RX_UNF];
    status_o[B_ERR]      = err_any;
    status_o[B_READY]    = flags[F_READY];
    status2_o = (32'(tx_free) << S2_TX_LSB) | (32'(rx_cnt) << S2_RX_LSB);
  end

  assign irq_o = (flags[F_READY] && rdy_ie_i) || err_any;

  p_err_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[B_ERR] |-> irq_o);
  p_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_full) |=> status_o[B_TX_OVF] && status_o[B_ERR]);
  p_rxovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full) |=> status_o[B_RX_OVF]);
  p_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> status_o[B_READY]);
  p_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status2_o[S2_TX_LSB +: CW] <= CW'(DEPTH));
endmodule

// File: tb/tb_spi_fifo_status.sv
`timescale 1ns/1ps
module tb_spi_fifo_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_wr = 0, tx_pop = 0, rx_push = 0, rx_rd = 0, busy = 0, done = 0, ie = 0;
  logic sts_wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] st, st2;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_fifo_status dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_wr_i(tx_wr), .tx_pop_i(tx_pop),
    .rx_push_i(rx_push), .rx_rd_i(rx_rd), .busy_i(busy), .done_i(done),
    .rdy_ie_i(ie), .sts_wr_i(sts_wr), .sts_wdata_i(wdata),
    .status_o(st), .status2_o(st2), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_n(ref logic s, input int n);
    for (int i = 0; i < n; i++) begin s = 1; step(); end
    s = 0;
  endtask

  task automatic w1c(input logic [31:0] d);
    wdata = d; sts_wr = 1; step(); sts_wr = 0; wdata = '0;
  endtask

  task automatic t_reset();
    chk("R1 tx free", st2[5:0], 32);
    chk("R1 rx count", st2[21:16], 0);
    chk("R1 status", st, 32'h0000_000A);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx_fill();
    pulse_n(tx_wr, 5);
    chk("R2 free after 5", st2[5:0], 27);
    chk("R2 not empty", st[1], 0);
    tx_wr = 1; tx_pop = 1; step(); tx_wr = 0; tx_pop = 0;
    chk("R14 tx simul", st2[5:0], 27);
    pulse_n(tx_wr, 27);
    chk("R2 full free", st2[5:0], 0);
    chk("R2 full bit", st[0], 1);
    chk("R3 no ovf yet", st[8], 0);
    pulse_n(tx_wr, 1);
    chk("R3 ovf set", st[8], 1);
    chk("R3 count held", st2[5:0], 0);
    chk("R10 err", st[12], 1);
    chk("R12 irq err", irq, 1);
  endtask

  task automatic t_w1c();
    w1c(~32'h0000_0100);
    chk("R8 zero keeps", st[8], 1);
    // race: overflow again while clearing
    tx_wr = 1; wdata = 32'h100; sts_wr = 1; step();
    tx_wr = 0; sts_wr = 0; wdata = '0;
    chk("R9 set wins", st[8], 1);
    w1c(32'h100);
    chk("R8 cleared", st[8], 0);
    chk("R10 err clear", st[12], 0);
    chk("R12 irq clear", irq, 0);
  endtask

  task automatic t_tx_drain();
    pulse_n(tx_pop, 32);
    chk("R2 drained", st2[5:0], 32);
    chk("R2 empty bit", st[1], 1);
    pulse_n(tx_pop, 1);
    chk("R4 unf", st[9], 1);
    chk("R4 count", st2[5:0], 32);
    w1c(32'h200);
    chk("R8 unf clr", st[9], 0);
  endtask

  task automatic t_rx();
    pulse_n(rx_rd, 1);
    chk("R7 unf", st[11], 1);
    chk("R7 count", st2[21:16], 0);
    w1c(32'h800);
    pulse_n(rx_push, 32);
    chk("R5 count", st2[21:16], 32);
    chk("R5 full", st[2], 1);
    chk("R5 not empty", st[3], 0);
    pulse_n(rx_push, 1);
    chk("R6 ovf", st[10], 1);
    chk("R6 count", st2[21:16], 32);
    pulse_n(rx_rd, 3);
    chk("R5 after reads", st2[21:16], 29);
    rx_push = 1; rx_rd = 1; step(); rx_push = 0; rx_rd = 0;
    chk("R14 rx simul", st2[21:16], 29);
    w1c(32'h400);
    chk("R6 cleared", st[10], 0);
  endtask

  task automatic t_ready();
    busy = 1; #1;
    chk("R13 busy", st[4], 1);
    busy = 0; #1;
    chk("R13 idle", st[4], 0);
    pulse_n(done, 1);
    chk("R11 ready", st[13], 1);
    chk("R12 masked", irq, 0);
    ie = 1; #1;
    chk("R12 enabled", irq, 1);
    w1c(32'h0000_0F00);
    chk("R8 ready kept", st[13], 1);
    w1c(32'h2000);
    chk("R11 ready clr", st[13], 0);
    chk("R12 irq low", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_tx_fill();
    t_w1c();
    t_tx_drain();
    t_rx();
    t_ready();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule